// File: doc/BRIEF.md
# Inter-processor and interval-timer interrupt controller

This block holds the interrupt state shared by up to four processors: one 64-bit control word (the event register) and one interval ignore counter for each processor. Any processor can raise an inter-processor interrupt (IPI) on any processor, acknowledge IPIs and timer flags, and claim arbitration fields, all by writing the event register. Its bit fields follow different write rules: some are cleared by writing one, some are set by writing one, one field can be set only while it is empty, and one nibble is plain read/write.

A shared timer tick drives the counters. On every rising edge of the tick, each present processor's counter counts down by one as a 25-bit value. Its top bit is the overflow bit. Once the count passes zero that bit stays set, and from then on each tick raises that processor's timer flag and its timer interrupt. Software reloads a counter to hold back timer interrupts for a given number of ticks. A present vector masks the outputs of processors that do not exist and freezes their counters.

The register port is a flat strobe port with a combinational read. The address selects either the event register or one processor's counter. The requesting processor's index travels with every access.

Top module: `cpu_event_ctl`

## Requirements
- R1: After a synchronous reset the event register reads as bit 35 set (revision indicator) with all other stored bits zero, every counter reads zero, and every ipi_irq and tmr_irq output is low.
- R2: Address 0 reads the event register with the requesting processor's index (reg_cpu) ORed into bits 1:0. Address 4+n reads counter n zero-extended to 64 bits. Any other address reads zero and ignores writes.
- R3: Writing 1 to any of bits 4-7 (timer flags), bits 8-11 (IPI flags) or bit 28 clears that bit. Writing 0 leaves it unchanged.
- R4: Writing 1 to bit 12+n sets IPI flag bit 8+n. This set takes priority over a clear of the same flag in the same write. Bits 12-15 are never stored.
- R5: A write with bit 20 set clears bits 16-23 and sets none of them.
- R6: A write with bit 20 clear sets each of bits 20-23 for which the written bit is 1.
- R7: A write with bit 20 clear loads the 1s of written bits 16-19 only if stored bits 16-19 are all zero. Otherwise that field is unchanged.
- R8: Bits 40-43 take the written value on every event-register write. All bits not named in R3-R8 ignore writes.
- R9: Writing counter n stores the low 24 written bits and clears its overflow bit 24.
- R10: On each rising tick edge, every present processor's counter not written in that cycle becomes (count-1) mod 2^25 with bit 24 kept once set. A tick held high or falling changes nothing.
- R11: A tick after which counter n has bit 24 set sets timer flag bit 4+n. tmr_irq[n] is high exactly while that flag is set and processor n is present, so only a clearing write (R3) lowers it.
- R12: ipi_irq[n] equals IPI flag bit 8+n while processor n is present. An absent processor has both outputs low and a frozen counter, while its flags stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_present | input | NCPU | One bit per processor that exists |
| reg_addr | input | IDX_W+1 | 0 = event register, 4+n = counter n |
| reg_cpu | input | IDX_W | Index of the requesting processor |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data |
| tick | input | 1 | Shared interval timer tick, rising edge counts |
| ipi_irq | output | NCPU | Inter-processor interrupt per processor |
| tmr_irq | output | NCPU | Interval timer interrupt per processor |

## Verification
On every cycle the assertions check the per-field write rules of the event register: clear-by-one, IPI set priority, arbitration clear, the zero-only load of bits 16-19 and the read/write nibble. They also check that timer flags fall only on a clearing write, that a counter load and a single-step decrement land correctly, that the overflow bit is sticky, and that a tick yields a one-cycle rising event. Only the bench's scenarios show the read format with the requester index, the long run of overflowed ticks re-raising a cleared flag, the masking of absent processors, and the exact register values after each table write.

// File: rtl/cpu_evt_pkg.sv
`timescale 1ns/1ps
package cpu_evt_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned CNT_W     = 25;
  localparam int unsigned LOAD_W    = 24;
  localparam int unsigned SLOTS     = 4;
  localparam int unsigned TMR_LSB   = 4;
  localparam int unsigned IPI_LSB   = 8;
  localparam int unsigned REQ_LSB   = 12;
  localparam int unsigned ARB_LSB   = 16;
  localparam int unsigned ARB_CLR   = 20;
  localparam int unsigned ERR_BIT   = 28;
  localparam int unsigned REV_BIT   = 35;
  localparam int unsigned RW_LSB    = 40;
  localparam logic [DATA_W-1:0] EVT_RESET = 64'h1 << REV_BIT;

  // Event register update for one write, all field rules applied in order:
  // clears first, then arbitration, then IPI requests, then the rw nibble.
  function automatic logic [DATA_W-1:0] evt_apply_write(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] wd);
    logic [DATA_W-1:0] n;
    n = cur;
    n[IPI_LSB+3:TMR_LSB] = n[IPI_LSB+3:TMR_LSB] & ~wd[IPI_LSB+3:TMR_LSB];
    n[ERR_BIT] = n[ERR_BIT] & ~wd[ERR_BIT];
    if (wd[ARB_CLR]) begin
      n[ARB_LSB+7:ARB_LSB] = '0;
    end else begin
      n[ARB_LSB+7:ARB_LSB+4] = n[ARB_LSB+7:ARB_LSB+4] | wd[ARB_LSB+7:ARB_LSB+4];
      if (n[ARB_LSB+3:ARB_LSB] == 4'h0)
        n[ARB_LSB+3:ARB_LSB] = wd[ARB_LSB+3:ARB_LSB];
    end
    n[IPI_LSB+3:IPI_LSB] = n[IPI_LSB+3:IPI_LSB] | wd[REQ_LSB+3:REQ_LSB];
    n[RW_LSB+3:RW_LSB] = wd[RW_LSB+3:RW_LSB];
    return n;
  endfunction

  // 25-bit countdown with a sticky overflow bit.
  function automatic logic [CNT_W-1:0] ign_step(input logic [CNT_W-1:0] c);
    return (c - CNT_W'(1)) | {c[CNT_W-1], {(CNT_W-1){1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] evt_read(
      input logic [DATA_W-1:0] stored, input logic [1:0] who);
    return stored | {{(DATA_W-2){1'b0}}, who};
  endfunction
endpackage

// File: rtl/tick_edge.sv
`timescale 1ns/1ps
module tick_edge (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic rise
);
  logic tick_d;

  always_ff @(posedge clk) begin
    if (rst) tick_d <= 1'b0;
    else     tick_d <= tick;
  end

  assign rise = tick & ~tick_d;

  // R10: a held tick yields only one rising event
  a_r10_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ign_counter.sv
`timescale 1ns/1ps
module ign_counter
  import cpu_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              step,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_evt
);
  logic [CNT_W-1:0] nxt;

  assign nxt     = ign_step(cnt);
  assign ovf_evt = step & nxt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= {1'b0, load_val};
    else if (step) cnt <= nxt;
  end

  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == {1'b0, $past(load_val)});

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt[CNT_W-1]) |=> cnt[CNT_W-1]);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt));

  a_r10_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt[LOAD_W-1:0] != '0) |=>
      cnt[LOAD_W-1:0] == $past(cnt[LOAD_W-1:0]) - LOAD_W'(1));
endmodule

// File: rtl/evt_reg.sv
`timescale 1ns/1ps
module evt_reg
  import cpu_evt_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  input  logic [NCPU-1:0]   tmr_set,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] n;

  always_comb begin
    n = we ? evt_apply_write(q, wd) : q;
    for (int i = 0; i < NCPU; i++)
      n[TMR_LSB+i] = n[TMR_LSB+i] | tmr_set[i];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= EVT_RESET;
    else     q <= n;
  end

  a_r5_arb_clear: assert property (@(posedge clk) disable iff (rst)
    (we && wd[ARB_CLR]) |=> q[ARB_LSB+7:ARB_LSB] == 8'h00);

  a_r7_zero_only: assert property (@(posedge clk) disable iff (rst)
    (we && !wd[ARB_CLR] && q[ARB_LSB+3:ARB_LSB] != 4'h0) |=>
      $stable(q[ARB_LSB+3:ARB_LSB]));

  a_r8_rw_nibble: assert property (@(posedge clk) disable iff (rst)
    we |=> q[RW_LSB+3:RW_LSB] == $past(wd[RW_LSB+3:RW_LSB]));

  a_r3_err_clear: assert property (@(posedge clk) disable iff (rst)
    (we && wd[ERR_BIT]) |=> !q[ERR_BIT]);

  for (genvar g = 0; g < NCPU; g++) begin : g_chk
    a_r3_ipi_clear: assert property (@(posedge clk) disable iff (rst)
      (we && wd[IPI_LSB+g] && !wd[REQ_LSB+g]) |=> !q[IPI_LSB+g]);
    a_r4_ipi_set: assert property (@(posedge clk) disable iff (rst)
      (we && wd[REQ_LSB+g]) |=> q[IPI_LSB+g]);
    a_r11_flag_set: assert property (@(posedge clk) disable iff (rst)
      tmr_set[g] |=> q[TMR_LSB+g]);
    a_r11_flag_fall: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(q[TMR_LSB+g])) |->
        $past(we && wd[TMR_LSB+g]));
  end
endmodule

// File: rtl/cpu_event_ctl.sv
`timescale 1ns/1ps
module cpu_event_ctl
  import cpu_evt_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCPU-1:0]   cpu_present,
  input  logic [IDX_W:0]    reg_addr,
  input  logic [IDX_W-1:0]  reg_cpu,
  input  logic              reg_we,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              tick,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  localparam logic [IDX_W:0] EVT_ADDR = '0;

  logic              tick_rise;
  logic              evt_we;
  logic [NCPU-1:0]   cnt_we;
  logic [NCPU-1:0]   cnt_step;
  logic [NCPU-1:0]   ovf_evt;
  logic [DATA_W-1:0] evt_q;
  logic [CNT_W-1:0]  cnt_q [NCPU];

  tick_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .rise (tick_rise)
  );

  assign evt_we = reg_we && (reg_addr == EVT_ADDR);

  evt_reg #(.NCPU(NCPU)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .we      (evt_we),
    .wd      (reg_wdata),
    .tmr_set (ovf_evt),
    .q       (evt_q)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    localparam logic [IDX_W:0] CNT_ADDR = (IDX_W+1)'((1 << IDX_W) + g);
    assign cnt_we[g]   = reg_we && (reg_addr == CNT_ADDR);
    assign cnt_step[g] = tick_rise & cpu_present[g] & ~cnt_we[g];

    ign_counter u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_we[g]),
      .load_val (reg_wdata[LOAD_W-1:0]),
      .step     (cnt_step[g]),
      .cnt      (cnt_q[g]),
      .ovf_evt  (ovf_evt[g])
    );

    assign ipi_irq[g] = evt_q[IPI_LSB+g] & cpu_present[g];
    assign tmr_irq[g] = evt_q[TMR_LSB+g] & cpu_present[g];

    a_r12_absent_frozen: assert property (@(posedge clk) disable iff (rst)
      (!cpu_present[g] && !cnt_we[g]) |=> $stable(cnt_q[g]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == EVT_ADDR) begin
      reg_rdata = evt_read(evt_q, 2'(reg_cpu));
    end else begin
      for (int i = 0; i < NCPU; i++)
        if (reg_addr == (IDX_W+1)'((1 << IDX_W) + i))
          reg_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_q[i]};
    end
  end
endmodule

// File: tb/cpu_event_ctl_tb.sv
`timescale 1ns/1ps
module cpu_event_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cpu_present = 4'hF;
  logic [2:0]  reg_addr = '0;
  logic [1:0]  reg_cpu = '0;
  logic        reg_we = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        tick = 1'b0;
  logic [3:0]  ipi_irq, tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_event_ctl u_dut (
    .clk(clk), .rst(rst), .cpu_present(cpu_present), .reg_addr(reg_addr),
    .reg_cpu(reg_cpu), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  // event register write data and expected stored value afterwards
  localparam logic [63:0] WV [12] = '{
    64'h0000_0000_0000_F000, 64'h0000_0000_0000_0300,
    64'h0000_0000_0000_1100, 64'h0000_0000_00A5_0000,
    64'h0000_0000_000A_0000, 64'h0000_0000_0040_0000,
    64'h0000_0000_0013_0000, 64'h0000_0000_0003_0000,
    64'h0000_0F00_0000_0000, 64'h0000_0500_0000_0000,
    64'hFFFF_F0F7_0000_000F, 64'h0000_0000_1000_0C00 };
  localparam logic [63:0] EV [12] = '{
    64'h0000_0008_0000_0F00, 64'h0000_0008_0000_0C00,
    64'h0000_0008_0000_0D00, 64'h0000_0008_00A5_0D00,
    64'h0000_0008_00A5_0D00, 64'h0000_0008_00E5_0D00,
    64'h0000_0008_0000_0D00, 64'h0000_0008_0003_0D00,
    64'h0000_0F08_0003_0D00, 64'h0000_0508_0003_0D00,
    64'h0000_0008_0003_0D00, 64'h0000_0008_0003_0100 };
  localparam string TAG [12] = '{"R4","R3","R4","R6 R7","R7","R6","R5","R7",
                                 "R8","R8","R8","R3"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] who, output logic [63:0] d);
    reg_addr = a; reg_cpu = who;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_cnt(input string req, input int n, input logic [63:0] exp);
    logic [63:0] d;
    rd(3'(4 + n), 2'd0, d);
    chk(req, d, exp);
  endtask

  initial begin
    logic [63:0] d;
    do_reset();
    // R1 reset state, R2 requester index in bits 1:0
    rd(3'd0, 2'd3, d);  chk("R1 R2 reset read idx3", d, 64'h8_0000_0003);
    rd(3'd0, 2'd0, d);  chk("R1 reset read", d, 64'h8_0000_0000);
    for (int n = 0; n < 4; n++) chk_cnt("R1 counter reset", n, 64'h0);
    chk("R1 outputs", {56'h0, ipi_irq, tmr_irq}, 64'h0);

    // table of event register writes
    for (int k = 0; k < 12; k++) begin
      wr(3'd0, WV[k]);
      rd(3'd0, 2'(k % 4), d);
      chk(TAG[k], d, EV[k] | 64'(k % 4));
      chk("R12 ipi follows flags", {60'h0, ipi_irq}, {60'h0, EV[k][11:8]});
    end

    // R2 unmapped address reads zero, write ignored
    wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd1, 2'd0, d);  chk("R2 unmapped read", d, 64'h0);
    rd(3'd0, 2'd0, d);  chk("R2 unmapped write ignored", d, 64'h8_0003_0100);

    // counters and tick
    do_reset();
    cpu_present = 4'b0111;
    wr(3'd4, 64'h0000_0000_0123_4567);
    chk_cnt("R9 load low 24 bits", 0, 64'h0023_4567);
    wr(3'd4, 64'd2); wr(3'd5, 64'd0); wr(3'd6, 64'd5); wr(3'd7, 64'd3);
    pulse_tick();
    chk_cnt("R10 decrement", 0, 64'd1);
    chk_cnt("R10 wrap sets bit24", 1, 64'h1FF_FFFF);
    chk_cnt("R12 absent frozen", 3, 64'd3);
    rd(3'd0, 2'd0, d); chk("R11 flag set", d, 64'h8_0000_0020);
    chk("R11 tmr irq", {60'h0, tmr_irq}, 64'h2);
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    chk_cnt("R10 held tick one step", 2, 64'd3);
    chk_cnt("R10 falling ignored", 0, 64'd0);
    chk_cnt("R10 sticky", 1, 64'h1FF_FFFE);
    wr(3'd0, 64'h20);
    chk("R11 clear lowers irq", {60'h0, tmr_irq}, 64'h0);
    pulse_tick();
    chk_cnt("R10 wrap from zero", 0, 64'h1FF_FFFF);
    rd(3'd0, 2'd0, d); chk("R11 reflag after clear", d, 64'h8_0000_0030);
    chk("R11 tmr irq both", {60'h0, tmr_irq}, 64'h3);
    wr(3'd5, 64'd7);
    chk_cnt("R9 reload clears bit24", 1, 64'd7);
    chk("R11 reload keeps irq", {60'h0, tmr_irq}, 64'h3);
    wr(3'd0, 64'h20);
    pulse_tick();
    chk_cnt("R10 step after reload", 1, 64'd6);
    rd(3'd0, 2'd0, d); chk("R11 no flag without bit24", d, 64'h8_0000_0010);
    // R12 absent processor masking
    wr(3'd0, 64'h8000);
    rd(3'd0, 2'd0, d); chk("R12 flag readable", d, 64'h8_0000_0810);
    chk("R12 absent ipi low", {60'h0, ipi_irq}, 64'h0);
    cpu_present = 4'hF;
    #1 chk("R12 present ipi", {60'h0, ipi_irq}, 64'h8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule